// File: doc/BRIEF.md
# SD Card Clock Generator with Data Timeout

This block produces the SD card clock from the core clock with a programmable integer divider. The register holds N, and the card clock runs at core/(N+2). The divider field is 11 bits wide. Its largest value gives the slowest clock. No setting stops the clock.

The protocol side reports with `data_phase` when the card has moved from identification into data transfer. In that phase the divider uses only the low three bits of N, unless software has set the slow-card bit. The slow-card bit keeps the full 11-bit divisor in every phase. A divider change never shortens the period in progress. It is applied at the next rising edge of the card clock.

A 32-bit down-counter measures data wait periods in card clock cycles. The data path pulses `wait_load` when a wait period begins. It holds `wait_active` high while the wait is running. The block raises `tmo_expired` for one core cycle when the count runs out.

Software writes three registers over a plain write port:
- select 0: the divider N, in `cfg_wdata[10:0]`
- select 1: the timeout start value, in `cfg_wdata[31:0]`
- select 2: the configuration, with the slow-card bit in `cfg_wdata[0]`

A write takes effect in the cycle after the one in which `cfg_wr` is sampled high. All ports are plain control or status signals, with no handshake.

Top module: `sdclk_gen`

## Requirements
- R1: Reset state:
  - After reset the divider is 0, the slow-card bit is 0 and the timeout start value is 0xF00000.
  - While reset is held, `sd_clk` and `tmo_expired` are 0.
  - `sd_clk` rises on the first core edge after reset is released and then toggles at core/2.
- R2: In identification phase (`data_phase`=0), the card clock period is N+2 core cycles. Each period is high for floor((N+2)/2) cycles, starting at the rising edge, and low for the rest.
- R3: In data phase with the slow-card bit clear, only bits [2:0] of N set the period. The period is then N[2:0]+2.
- R4: With the slow-card bit (select 2, bit 0) set, the full 11-bit N sets the period even in data phase.
- R5: The divider, the phase and the slow-card bit are sampled only at a rising edge of `sd_clk`. The period already running completes with its old length, so no runt pulse is produced.
- R6: N=0x7FF gives a period of 2049 core cycles, high for 1024. The low phase never lasts longer than 1025 core cycles.
- R7: `wait_load` loads the start value S. Each later rising edge of `sd_clk`, while `wait_active` is high, counts down by one. `tmo_expired` is high for one core cycle, in the same cycle that `sd_clk` rises, on the S-th such edge. A start value of 0 behaves as 1.
- R8: After `tmo_expired` has fired, no further pulse occurs until the next `wait_load`.
- R9: A `wait_load` in the same cycle as the edge that would expire the count reloads the counter, and no pulse is produced.
- R10: Rising edges that occur while `wait_active` is low do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 divider, 1 timeout start, 2 configuration |
| cfg_wdata | input | 32 | Register write data |
| data_phase | input | 1 | High while the card is in data-transfer phase |
| wait_load | input | 1 | Start of a data wait period; reloads the timeout counter |
| wait_active | input | 1 | Timeout counting enable |
| sd_clk | output | 1 | Card clock |
| tmo_expired | output | 1 | One-cycle timeout pulse, aligned to a rising edge of `sd_clk` |

## Verification
Two events can fall in the same core cycle:
- a rising edge of `sd_clk` that ends the count
- a reload from `wait_load`

The bench uses its reference model to predict the cycle whose edge would expire the count. It asserts `wait_load` in exactly that cycle. It then judges that no pulse appears, and that the full start value is counted again before the next pulse.

A divider write in the first cycle of a period is a second coincidence. It is judged by measuring that the running period keeps its old length and that the next period has the new one.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  typedef enum logic [1:0] {
    SEL_DIV = 2'd0,
    SEL_TMO = 2'd1,
    SEL_CFG = 2'd2
  } sdclk_sel_e;

  localparam int CFG_SLOW_BIT = 0;
endpackage

// File: rtl/sdclk_regs.sv
module sdclk_regs
  import sdclk_pkg::*;
#(
  parameter int DIV_W    = 11,
  parameter int TMO_W    = 32,
  parameter logic [TMO_W-1:0] TMO_INIT = 32'h00F0_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [TMO_W-1:0] wr_data,
  output logic [DIV_W-1:0] div_n,
  output logic [TMO_W-1:0] tmo_start,
  output logic             slow_card
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_n     <= '0;
      tmo_start <= TMO_INIT;
      slow_card <= 1'b0;
    end else if (wr_en) begin
      case (sdclk_sel_e'(wr_sel))
        SEL_DIV: div_n     <= wr_data[DIV_W-1:0];
        SEL_TMO: tmo_start <= wr_data;
        SEL_CFG: slow_card <= wr_data[CFG_SLOW_BIT];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sdclk_divgen.sv
module sdclk_divgen #(
  parameter int DIV_W     = 11,
  parameter int FAST_BITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_n,
  input  logic             slow_card,
  input  logic             data_phase,
  output logic             sd_clk,
  output logic             rise
);
  localparam int CNT_W = DIV_W + 1;

  logic [DIV_W-1:0] eff_n;
  logic [CNT_W-1:0] next_len;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cur_len;
  logic             clk_q;

  // Divisor selection: narrow field in data phase unless slow-card is set
  generate
    if (FAST_BITS >= DIV_W) begin : g_full_only
      assign eff_n = div_n;
    end else begin : g_narrow
      assign eff_n = (data_phase && !slow_card)
                   ? {{(DIV_W-FAST_BITS){1'b0}}, div_n[FAST_BITS-1:0]}
                   : div_n;
    end
  endgenerate

  assign next_len = {1'b0, eff_n} + CNT_W'(2);
  assign rise     = (cnt == cur_len - CNT_W'(1));

  // A new length is latched only when a period wraps (rising edge of sd_clk)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= CNT_W'(1);
      cur_len <= CNT_W'(2);
      clk_q   <= 1'b0;
    end else if (rise) begin
      cnt     <= '0;
      cur_len <= next_len;
      clk_q   <= 1'b1;
    end else begin
      cnt     <= cnt + CNT_W'(1);
      clk_q   <= ((cnt + CNT_W'(1)) < (cur_len >> 1));
    end
  end

  assign sd_clk = clk_q;
endmodule

// File: rtl/sdclk_tmo.sv
module sdclk_tmo #(
  parameter int TMO_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMO_W-1:0] start_val,
  input  logic             load,
  input  logic             active,
  input  logic             tick,
  output logic             expired
);
  logic [TMO_W-1:0] remain;
  logic             armed;
  logic             pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain  <= '0;
      armed   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (load) begin
      remain  <= start_val;
      armed   <= 1'b1;
      pulse_q <= 1'b0;
    end else if (armed && active && tick) begin
      if (remain <= TMO_W'(1)) begin
        remain  <= '0;
        armed   <= 1'b0;
        pulse_q <= 1'b1;
      end else begin
        remain  <= remain - TMO_W'(1);
        pulse_q <= 1'b0;
      end
    end else begin
      pulse_q <= 1'b0;
    end
  end

  assign expired = pulse_q;
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
  parameter int DIV_W     = 11,
  parameter int FAST_BITS = 3,
  parameter int TMO_W     = 32,
  parameter logic [TMO_W-1:0] TMO_INIT = 32'h00F0_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_sel,
  input  logic [TMO_W-1:0] cfg_wdata,
  input  logic             data_phase,
  input  logic             wait_load,
  input  logic             wait_active,
  output logic             sd_clk,
  output logic             tmo_expired
);
  logic [DIV_W-1:0] div_n;
  logic [TMO_W-1:0] tmo_start;
  logic             slow_card;
  logic             edge_tick;

  sdclk_regs #(.DIV_W(DIV_W), .TMO_W(TMO_W), .TMO_INIT(TMO_INIT)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr),
    .wr_sel    (cfg_sel),
    .wr_data   (cfg_wdata),
    .div_n     (div_n),
    .tmo_start (tmo_start),
    .slow_card (slow_card)
  );

  sdclk_divgen #(.DIV_W(DIV_W), .FAST_BITS(FAST_BITS)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_n      (div_n),
    .slow_card  (slow_card),
    .data_phase (data_phase),
    .sd_clk     (sd_clk),
    .rise       (edge_tick)
  );

  sdclk_tmo #(.TMO_W(TMO_W)) u_tmo (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_val (tmo_start),
    .load      (wait_load),
    .active    (wait_active),
    .tick      (edge_tick),
    .expired   (tmo_expired)
  );
endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk #(
  parameter int DIV_W = 11
) (
  input logic clk,
  input logic rst_n,
  input logic wait_load,
  input logic wait_active,
  input logic sd_clk,
  input logic tmo_expired
);
  localparam int LONGEST = (1 << DIV_W) + 1;
  localparam int LOW_MAX = LONGEST - LONGEST / 2;

  int unsigned low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_run <= 0;
    else if (sd_clk) low_run <= 0;
    else             low_run <= low_run + 1;
  end

  // R6: the card clock never stays low beyond the slowest setting
  p_low_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= LOW_MAX);

  // R7: a timeout pulse coincides with a rising card clock edge
  p_pulse_on_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_expired |-> $rose(sd_clk));

  // R8: a pulse lasts a single core cycle
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_expired |=> !tmo_expired);

  // R9: a reload never produces a pulse in the following cycle
  p_reload_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wait_load |=> !tmo_expired);

  // R10: no expiry while counting is disabled
  p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_active |=> !tmo_expired);
endmodule

bind sdclk_gen sdclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wait_load   (wait_load),
  .wait_active (wait_active),
  .sd_clk      (sd_clk),
  .tmo_expired (tmo_expired)
);

// File: tb/tb_sdclk_gen.sv
`timescale 1ns/1ps
module tb_sdclk_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        data_phase = 1'b0;
  logic        wait_load = 1'b0;
  logic        wait_active = 1'b0;
  logic        sd_clk;
  logic        tmo_expired;

  always #2 clk = ~clk;

  sdclk_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .data_phase(data_phase), .wait_load(wait_load),
    .wait_active(wait_active), .sd_clk(sd_clk), .tmo_expired(tmo_expired)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    pulse_cnt = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  task automatic check(input string req, input longint act, input longint exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // Behavioural reference model
  int          m_div, m_slow, m_pos, m_len, m_clk, m_armed, m_pulse;
  logic [31:0] m_start, m_left;

  always @(posedge clk) begin : model
    int  eff;
    bit  edge_now;
    if (!rst_n) begin
      m_div = 0; m_slow = 0; m_start = 32'h00F0_0000;
      m_pos = 1; m_len = 2; m_clk = 0; m_left = 0; m_armed = 0; m_pulse = 0;
    end else begin
      edge_now = (m_pos == m_len - 1);
      eff = (data_phase && m_slow == 0) ? (m_div % 8) : m_div;
      if (wait_load) begin
        m_left = m_start; m_armed = 1; m_pulse = 0;
      end else if (m_armed != 0 && wait_active && edge_now) begin
        if (m_left <= 1) begin m_left = 0; m_armed = 0; m_pulse = 1; end
        else begin m_left = m_left - 1; m_pulse = 0; end
      end else m_pulse = 0;
      if (edge_now) begin m_len = eff + 2; m_pos = 0; end
      else m_pos = m_pos + 1;
      m_clk = (m_pos < m_len / 2) ? 1 : 0;
      if (cfg_wr) begin
        case (cfg_sel)
          2'd0: m_div = int'(cfg_wdata[10:0]);
          2'd1: m_start = cfg_wdata;
          2'd2: m_slow = int'(cfg_wdata[0]);
          default: ;
        endcase
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, longint'(sd_clk), longint'(m_clk), "sd_clk vs model");
      check(cur_req, longint'(tmo_expired), longint'(m_pulse), "tmo_expired vs model");
      if (tmo_expired) pulse_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      finish_run();
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); #1;
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic sync_rise();
    int prev;
    prev = sd_clk;
    forever begin
      @(negedge clk);
      if (prev == 0 && sd_clk) break;
      prev = sd_clk;
    end
  endtask

  task automatic measure(output int per, output int hi);
    int prev;
    sync_rise();
    per = 0; hi = 0;
    forever begin
      per++;
      if (sd_clk) hi++;
      prev = sd_clk;
      @(negedge clk);
      if (prev == 0 && sd_clk) break;
    end
  endtask

  task automatic period_ok(input string req, input int exp_len);
    int per, hi;
    measure(per, hi);
    measure(per, hi);
    check(req, per, exp_len, "period");
    check(req, hi, exp_len / 2, "high cycles");
  endtask

  // Load the counter, optionally hold counting off, then count edges to the pulse
  task automatic run_tmo(input string req, input logic [31:0] start, input int hold, input int exp_edges);
    int prev, edges, base, guard;
    wr(2'd1, start);
    base = pulse_cnt;
    wait_active = (hold == 0);
    wait_load = 1'b1;
    @(negedge clk); #1;
    wait_load = 1'b0;
    prev = sd_clk;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      prev = sd_clk;
    end
    check("R10", pulse_cnt - base, 0, "pulses while counting disabled");
    #1 wait_active = 1'b1;
    edges = 0; guard = 0;
    while (pulse_cnt == base && guard < 6000) begin
      @(negedge clk);
      if (prev == 0 && sd_clk) edges++;
      prev = sd_clk;
      guard++;
    end
    check(req, edges, exp_edges, "edges counted at pulse");
    repeat (40) @(negedge clk);
    check("R8", pulse_cnt - base, 1, "pulses after one load");
    #1 wait_active = 1'b0;
  endtask

  initial begin
    int per, hi, base, guard, prev, edges;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", sd_clk, 0, "sd_clk in reset");
    check("R1", tmo_expired, 0, "tmo_expired in reset");
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1", sd_clk, 1, "first edge after reset");
    period_ok("R1", 2);
    // R1: default start value does not expire in a short window
    base = pulse_cnt;
    #1 wait_active = 1'b1; wait_load = 1'b1;
    @(negedge clk); #1 wait_load = 1'b0;
    repeat (200) @(negedge clk);
    check("R1", pulse_cnt - base, 0, "default start value long");
    #1 wait_active = 1'b0;

    // R2: identification phase, odd and even divisors
    cur_req = "R2";
    wr(2'd0, 32'd5);  period_ok("R2", 7);
    wr(2'd0, 32'd2);  period_ok("R2", 4);
    wr(2'd0, 32'd13); period_ok("R2", 15);

    // R3: data phase uses the low three bits
    cur_req = "R3";
    #1 data_phase = 1'b1;
    period_ok("R3", 7);
    wr(2'd0, 32'h7F8); period_ok("R3", 2);

    // R4: slow-card bit forces the full divisor
    cur_req = "R4";
    wr(2'd0, 32'd13);
    wr(2'd2, 32'd1);  period_ok("R4", 15);
    wr(2'd2, 32'd0);  period_ok("R4", 7);
    #1 data_phase = 1'b0;

    // R5: divider write in the first cycle of a period
    cur_req = "R5";
    wr(2'd0, 32'd9);
    period_ok("R5", 11);
    sync_rise();
    #1 cfg_wr = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'd1;
    per = 1; prev = sd_clk;
    forever begin
      @(negedge clk);
      #1 cfg_wr = 1'b0;
      if (prev == 0 && sd_clk) break;
      prev = sd_clk;
      per++;
    end
    check("R5", per, 11, "period running at write");
    measure(per, hi);
    check("R5", per, 3, "period after write");

    // R6: slowest setting
    cur_req = "R6";
    wr(2'd0, 32'h7FF); period_ok("R6", 2049);

    // R7, R8, R10: timeout counting
    cur_req = "R7";
    wr(2'd0, 32'd0);
    run_tmo("R7", 32'd5, 0, 5);
    run_tmo("R7", 32'd0, 0, 1);
    wr(2'd0, 32'd4);
    cur_req = "R10";
    run_tmo("R10", 32'd4, 30, 4);

    // R9: reload in the cycle whose edge would expire the count
    cur_req = "R9";
    wr(2'd0, 32'd1);
    wr(2'd1, 32'd3);
    base = pulse_cnt;
    #1 wait_active = 1'b1; wait_load = 1'b1;
    @(negedge clk); #1 wait_load = 1'b0;
    guard = 0;
    while (!(m_armed != 0 && m_left <= 1 && m_pos == m_len - 1) && guard < 200) begin
      @(negedge clk); guard++;
    end
    #1 wait_load = 1'b1;
    @(negedge clk); #1 wait_load = 1'b0;
    prev = sd_clk;
    @(negedge clk);
    check("R9", pulse_cnt - base, 0, "no pulse on reload collision");
    edges = (prev == 0 && sd_clk) ? 1 : 0;
    prev = sd_clk; guard = 0;
    while (pulse_cnt == base && guard < 200) begin
      @(negedge clk);
      if (prev == 0 && sd_clk) edges++;
      prev = sd_clk; guard++;
    end
    check("R9", edges, 3, "full recount after collision");
    check("R9", pulse_cnt - base, 1, "one pulse after recount");
    #1 wait_active = 1'b0;
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule